// File: doc/BRIEF.md
# Dual-CAS DRAM Strobe Decoder

This block is the device-side control for a 16-bit dynamic memory that has one row strobe and two column strobes, one per byte lane. All five control inputs (row strobe, lower and upper column strobes, write enable and output enable) are active low. They are sampled on a fast system clock and decoded into a cycle class. The classes are idle, read, write, read-write, row-only refresh, hidden refresh and strobe-order refresh. The block latches the row and column halves of the address from one shared bus. It keeps its own refresh row counter. It drives per-lane write and output-enable gating around a small behavioural storage array, one array per byte lane.

The two column strobes are merged into one internal column strobe. That strobe goes active on the first lane to fall and goes inactive only when the last lane rises. Data gating still follows each lane's own strobe, so byte-wide reads and writes work. When the row strobe falls while either column strobe is already low, the cycle is a refresh. If a read was already driving data at that moment, the refresh is a hidden refresh and the data stays on the bus.

Top module: `dcas_dram_decoder`

## Requirements
- R1: After reset, `dout_en` is 0, `cyc_kind` is 0 (idle) and the refresh row counter is 0.
- R2: The merged column strobe goes active on the first lane strobe to fall, and the column address is latched at that moment. The cycle stays active until the last lane strobe rises. A lane that falls later writes to the column that is already latched.
- R3: The row is latched from `addr` when `ras_n` falls with both column strobes high. The column is latched from `addr` when the merged column strobe falls. Words at distinct row/column pairs are independent.
- R4: Read: `dout_en[0]` (bits 7:0) follows `lcas_n` and `dout_en[1]` (bits 15:8) follows `ucas_n`. A lane drives only when its strobe is low, `oe_n` is low and `we_n` is high, and it then shows the stored byte. `cyc_kind` is 1.
- R5: Write: `din` is stored at the later of the column-strobe and `we_n` falling edges, only in lanes whose strobe is low. The other lane keeps its old byte. `cyc_kind` is 2.
- R6: A `ras_n` fall while any column strobe is low, with no read data held, is a strobe-order refresh (`cyc_kind` 6). The opened row is the counter value, `addr` is ignored and `dout_en` stays 0.
- R7: A `ras_n` fall with both column strobes high and no later column fall is a row-only refresh (`cyc_kind` 4). The opened row comes from `addr` and `dout_en` is 0.
- R8: Hidden refresh: after a read, `ras_n` rises and falls again while the column strobes stay low. `cyc_kind` becomes 5, the counter row is opened, and the read data stays driven unchanged.
- R9: The refresh row counter advances by one after each strobe-order or hidden refresh, and wraps from 2^ADDR_W-1 to 0.
- R10: Every `ras_n` fall pulses `row_open` for exactly one clock, with `open_row` set to the row opened. Every row is therefore opened within a bounded window when refresh is swept.
- R11: Read-write: a `we_n` fall during a read cycle changes `cyc_kind` to 3 and stores `din` in the lanes whose strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Lower-lane column strobe, active low |
| ucas_n | input | 1 | Upper-lane column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Shared row/column address |
| din | input | 2*LANE_W | Write data |
| dout | output | 2*LANE_W | Read data |
| dout_en | output | 2 | Per-lane output drive enable (bit 0 = low byte) |
| cyc_kind | output | 3 | Cycle class: 0 idle, 1 read, 2 write, 3 read-write, 4 row-only, 5 hidden, 6 strobe-order refresh |
| row_open | output | 1 | One-clock pulse per row-strobe fall |
| open_row | output | ADDR_W | Row opened by the last row-strobe fall |

## Verification
The hardest situation to reach is the hidden refresh. It needs a completed read whose data is held on the bus, then a row-strobe rise and a second fall while both column strobes stay low. A careless stimulus would instead start a plain strobe-order refresh or end the read. The bench sets this up in a single continuous sequence: open a row, latch a column with output enable low, then toggle only the row strobe. It checks that the data stays driven on both sides of the toggle and that the counter row is opened. Counter wrap is reached by sweeping enough strobe-order refreshes to pass the top row.

// File: rtl/dcas_pkg.sv
package dcas_pkg;
  localparam int LANES = 2;

  typedef enum logic [2:0] {
    CYC_IDLE   = 3'd0,
    CYC_READ   = 3'd1,
    CYC_WRITE  = 3'd2,
    CYC_RDWR   = 3'd3,
    CYC_RONLY  = 3'd4,
    CYC_HIDDEN = 3'd5,
    CYC_CBR    = 3'd6
  } cyc_e;
endpackage

// File: rtl/dcas_sampler.sv
module dcas_sampler import dcas_pkg::*; #(
  parameter int ADDR_W = 4,
  parameter int DQ_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_n,
  input  logic [LANES-1:0]  cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   din,
  output logic              ras_q,
  output logic [LANES-1:0]  cas_q,
  output logic              we_q,
  output logic              oe_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DQ_W-1:0]   din_q,
  output logic              mcas_q,
  output logic              ras_fall,
  output logic              mcas_fall,
  output logic [LANES-1:0]  lane_fall,
  output logic              we_fall
);
  logic             ras_d, we_d;
  logic [LANES-1:0] cas_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      ras_q  <= 1'b1;
      cas_q  <= '1;
      we_q   <= 1'b1;
      oe_q   <= 1'b1;
      addr_q <= '0;
      din_q  <= '0;
      ras_d  <= 1'b1;
      cas_d  <= '1;
      we_d   <= 1'b1;
    end else begin
      ras_q  <= ras_n;
      cas_q  <= cas_n;
      we_q   <= we_n;
      oe_q   <= oe_n;
      addr_q <= addr;
      din_q  <= din;
      ras_d  <= ras_q;
      cas_d  <= cas_q;
      we_d   <= we_q;
    end
  end

  // merged strobe: low as soon as one lane is low, high only when all are high
  always_comb begin
    mcas_q    = &cas_q;
    mcas_fall = (&cas_d) & ~(&cas_q);
    ras_fall  = ras_d & ~ras_q;
    lane_fall = cas_d & ~cas_q;
    we_fall   = we_d & ~we_q;
  end
endmodule

// File: rtl/dcas_cycle_ctrl.sv
module dcas_cycle_ctrl import dcas_pkg::*; #(
  parameter int ADDR_W = 4,
  parameter int DQ_W   = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ras_q,
  input  logic [LANES-1:0]    cas_q,
  input  logic                we_q,
  input  logic                oe_q,
  input  logic [ADDR_W-1:0]   addr_q,
  input  logic [DQ_W-1:0]     din_q,
  input  logic                mcas_q,
  input  logic                ras_fall,
  input  logic                mcas_fall,
  input  logic [LANES-1:0]    lane_fall,
  input  logic                we_fall,
  output cyc_e                kind,
  output logic                row_open,
  output logic [ADDR_W-1:0]   open_row,
  output logic [2*ADDR_W-1:0] rd_addr,
  output logic [LANES-1:0]    wr_en,
  output logic [2*ADDR_W-1:0] wr_addr,
  output logic [DQ_W-1:0]     wr_data,
  output logic [LANES-1:0]    dout_en
);
  logic [ADDR_W-1:0] row_r, col_r, cnt_r, col_now;
  logic              in_rfsh, open_ok;
  logic [LANES-1:0]  rd_hold, rd_set, wr_go;

  always_comb begin
    open_ok = ~ras_q & ~in_rfsh & ~ras_fall;
    col_now = mcas_fall ? addr_q : col_r;
    for (int l = 0; l < LANES; l++) begin
      rd_set[l] = open_ok & ~cas_q[l] & ~oe_q & we_q;
      wr_go[l]  = open_ok & ~cas_q[l] & ~we_q & (mcas_fall | lane_fall[l] | we_fall);
    end
  end

  assign rd_addr = {row_r, col_r};

  always_ff @(posedge clk) begin
    if (rst) begin
      row_r    <= '0;
      col_r    <= '0;
      cnt_r    <= '0;
      in_rfsh  <= 1'b0;
      kind     <= CYC_IDLE;
      row_open <= 1'b0;
      open_row <= '0;
      rd_hold  <= '0;
      dout_en  <= '0;
      wr_en    <= '0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      row_open <= ras_fall;
      wr_en    <= wr_go;
      wr_addr  <= {row_r, col_now};
      wr_data  <= din_q;
      for (int l = 0; l < LANES; l++) begin
        rd_hold[l] <= ~cas_q[l] & (rd_hold[l] | rd_set[l]);
        dout_en[l] <= rd_hold[l] & ~cas_q[l] & ~oe_q & we_q;
      end
      if (ras_q) in_rfsh <= 1'b0;
      else if (ras_fall && !mcas_q) in_rfsh <= 1'b1;
      if (ras_fall) begin
        open_row <= mcas_q ? addr_q : cnt_r;
        if (mcas_q) row_r <= addr_q;
        else        cnt_r <= cnt_r + ADDR_W'(1);
      end
      if (open_ok && mcas_fall) col_r <= addr_q;
      if (ras_q && mcas_q)            kind <= CYC_IDLE;
      else if (ras_fall)              kind <= mcas_q ? CYC_RONLY : ((|rd_hold) ? CYC_HIDDEN : CYC_CBR);
      else if (open_ok && mcas_fall)  kind <= we_q ? CYC_READ : CYC_WRITE;
      else if (open_ok && we_fall && kind == CYC_READ) kind <= CYC_RDWR;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (cnt_r != $past(cnt_r)) |-> (cnt_r == ADDR_W'($past(cnt_r) + ADDR_W'(1)))); // R9
  AST_OPEN_PULSE: assert property (@(posedge clk) disable iff (rst)
    row_open |=> !row_open); // R10
  AST_CBR_HIZ: assert property (@(posedge clk) disable iff (rst)
    (kind == CYC_CBR) |-> (dout_en == '0)); // R6
endmodule

// File: rtl/dcas_lane_mem.sv
module dcas_lane_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/dcas_dram_decoder.sv
module dcas_dram_decoder import dcas_pkg::*; #(
  parameter int ADDR_W = 4,
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ras_n,
  input  logic                lcas_n,
  input  logic                ucas_n,
  input  logic                we_n,
  input  logic                oe_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [2*LANE_W-1:0] din,
  output logic [2*LANE_W-1:0] dout,
  output logic [1:0]          dout_en,
  output logic [2:0]          cyc_kind,
  output logic                row_open,
  output logic [ADDR_W-1:0]   open_row
);
  localparam int DQ_W = LANES * LANE_W;
  localparam int MA_W = 2 * ADDR_W;

  logic              ras_q, we_q, oe_q, mcas_q, ras_fall, mcas_fall, we_fall;
  logic [LANES-1:0]  cas_q, lane_fall, wr_en, en_w;
  logic [ADDR_W-1:0] addr_q;
  logic [DQ_W-1:0]   din_q, wr_data;
  logic [MA_W-1:0]   rd_addr, wr_addr;
  cyc_e              kind_w;

  dcas_sampler #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) u_smp (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n({ucas_n, lcas_n}),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din),
    .ras_q(ras_q), .cas_q(cas_q), .we_q(we_q), .oe_q(oe_q),
    .addr_q(addr_q), .din_q(din_q), .mcas_q(mcas_q), .ras_fall(ras_fall),
    .mcas_fall(mcas_fall), .lane_fall(lane_fall), .we_fall(we_fall)
  );

  dcas_cycle_ctrl #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) u_ctl (
    .clk(clk), .rst(rst), .ras_q(ras_q), .cas_q(cas_q), .we_q(we_q),
    .oe_q(oe_q), .addr_q(addr_q), .din_q(din_q), .mcas_q(mcas_q),
    .ras_fall(ras_fall), .mcas_fall(mcas_fall), .lane_fall(lane_fall),
    .we_fall(we_fall), .kind(kind_w), .row_open(row_open),
    .open_row(open_row), .rd_addr(rd_addr), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .dout_en(en_w)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dcas_lane_mem #(.AW(MA_W), .DW(LANE_W)) u_mem (
      .clk(clk), .wr_en(wr_en[g]), .wr_addr(wr_addr),
      .wr_data(wr_data[g*LANE_W +: LANE_W]), .rd_addr(rd_addr),
      .rd_data(dout[g*LANE_W +: LANE_W])
    );
  end

  assign dout_en  = en_w;
  assign cyc_kind = kind_w;

  AST_LO_RD_GATE: assert property (@(posedge clk) disable iff (rst)
    dout_en[0] |-> $past(!lcas_n && !oe_n && we_n, 2)); // R4
  AST_HI_RD_GATE: assert property (@(posedge clk) disable iff (rst)
    dout_en[1] |-> $past(!ucas_n && !oe_n && we_n, 2)); // R4
  AST_LO_WR_GATE: assert property (@(posedge clk) disable iff (rst)
    wr_en[0] |-> $past(!lcas_n && !ras_n && !we_n, 2)); // R5
  AST_HI_WR_GATE: assert property (@(posedge clk) disable iff (rst)
    wr_en[1] |-> $past(!ucas_n && !ras_n && !we_n, 2)); // R5
endmodule

// File: tb/test_dcas_dram_decoder.sv
module test_dcas_dram_decoder;
  localparam int F_OE = 0, F_DQ = 1, F_KIND = 2, F_ACT = 3;
  localparam int RET_CYC = 400;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ras_n = 1'b1, lcas_n = 1'b1, ucas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [3:0]  addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic [1:0]  dout_en;
  logic [2:0]  cyc_kind;
  logic        row_open;
  logic [3:0]  open_row;

  int n_chk = 0, n_fail = 0, cyc = 0, n_open = 0, exp_open = 0;
  int last_open [16];
  logic [3:0] last_act = '0;
  logic [3:0] exp_cnt = '0;

  string       tq[$];
  int          fq[$];
  logic [15:0] eq[$];
  logic [15:0] mq[$];
  event        smp_ev;

  always #2 clk = ~clk;

  dcas_dram_decoder i_dcas_dram_decoder (
    .clk(clk), .rst(rst), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din), .dout(dout),
    .dout_en(dout_en), .cyc_kind(cyc_kind), .row_open(row_open), .open_row(open_row)
  );

  initial for (int r = 0; r < 16; r++) last_open[r] = 0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!rst && row_open) begin
      last_open[open_row] <= cyc;
      last_act <= open_row;
      n_open <= n_open + 1;
    end
  end

  // monitor: pop expected items and compare with the live outputs
  initial begin
    string t; int f; logic [15:0] e, m, a;
    forever begin
      @(smp_ev);
      while (tq.size() > 0) begin
        t = tq.pop_front(); f = fq.pop_front(); e = eq.pop_front(); m = mq.pop_front();
        case (f)
          F_OE:    a = {14'b0, dout_en};
          F_DQ:    a = dout;
          F_KIND:  a = {13'b0, cyc_kind};
          default: a = {12'b0, last_act};
        endcase
        n_chk++;
        if ((a & m) !== (e & m)) begin
          n_fail++;
          $display("FAIL %s field %0d: actual %h expected %h", t, f, a & m, e & m);
        end
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  task automatic step();
    repeat (4) @(negedge clk);
  endtask

  task automatic chk(string tag, int fld, logic [15:0] e, logic [15:0] m);
    tq.push_back(tag); fq.push_back(fld); eq.push_back(e); mq.push_back(m);
    -> smp_ev;
    #0;
  endtask

  function automatic logic [15:0] lmask(logic [1:0] l);
    return {{8{l[1]}}, {8{l[0]}}};
  endfunction

  task automatic own(string tag, bit ok, int a, int e);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, a, e);
    end
  endtask

  task automatic idle_all();
    ras_n = 1; lcas_n = 1; ucas_n = 1; we_n = 1; oe_n = 1;
    step();
  endtask

  task automatic wr_cycle(logic [3:0] row, logic [3:0] col, logic [15:0] d, logic [1:0] ln);
    ras_n = 0; addr = row; exp_open++; step();
    addr = col; din = d; we_n = 0; step();
    lcas_n = ~ln[0]; ucas_n = ~ln[1]; step();
    chk("R5", F_KIND, 16'd2, 16'hFFFF);
    idle_all();
  endtask

  task automatic rd_cycle(logic [3:0] row, logic [3:0] col, logic [1:0] ln, logic [15:0] d, string tag);
    ras_n = 0; addr = row; exp_open++; step();
    addr = col; oe_n = 0; step();
    lcas_n = ~ln[0]; ucas_n = ~ln[1]; step();
    chk(tag, F_OE, {14'b0, ln}, 16'hFFFF);
    chk(tag, F_DQ, d, lmask(ln));
    chk("R4", F_KIND, 16'd1, 16'hFFFF);
    idle_all();
  endtask

  task automatic cbr(string tag);
    lcas_n = 0; ucas_n = 0; step();
    addr = ~exp_cnt; ras_n = 0; exp_open++; step();
    chk(tag, F_KIND, 16'd6, 16'hFFFF);
    chk(tag, F_ACT, {12'b0, exp_cnt}, 16'hFFFF);
    chk(tag, F_OE, 16'd0, 16'hFFFF);
    exp_cnt = exp_cnt + 4'd1;
    idle_all();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    step();
    chk("R1", F_OE, 16'd0, 16'hFFFF);
    chk("R1", F_KIND, 16'd0, 16'hFFFF);

    wr_cycle(4'd3, 4'd5, 16'hA55A, 2'b11);
    rd_cycle(4'd3, 4'd5, 2'b11, 16'hA55A, "R4");
    wr_cycle(4'd3, 4'd5, 16'h12FF, 2'b10);
    wr_cycle(4'd5, 4'd3, 16'h0F0F, 2'b11);
    rd_cycle(4'd3, 4'd5, 2'b11, 16'h125A, "R5");
    rd_cycle(4'd3, 4'd5, 2'b01, 16'h005A, "R4");
    rd_cycle(4'd5, 4'd3, 2'b11, 16'h0F0F, "R3");

    // R2: lower lane falls first, address changes, upper lane falls later
    ras_n = 0; addr = 4'd7; exp_open++; step();
    addr = 4'd9; din = 16'hBEEF; we_n = 0; step();
    lcas_n = 0; step();
    addr = 4'd2; step();
    ucas_n = 0; step();
    lcas_n = 1; step();
    chk("R2", F_KIND, 16'd2, 16'hFFFF);
    ucas_n = 1;
    idle_all();
    rd_cycle(4'd7, 4'd9, 2'b11, 16'hBEEF, "R2");

    // R7: row-only refresh
    ras_n = 0; addr = 4'd11; exp_open++; step();
    chk("R7", F_KIND, 16'd4, 16'hFFFF);
    chk("R7", F_ACT, 16'd11, 16'hFFFF);
    chk("R7", F_OE, 16'd0, 16'hFFFF);
    idle_all();

    cbr("R6");

    // R8: hidden refresh after a read
    ras_n = 0; addr = 4'd3; exp_open++; step();
    addr = 4'd5; oe_n = 0; step();
    lcas_n = 0; ucas_n = 0; step();
    chk("R8", F_DQ, 16'h125A, 16'hFFFF);
    ras_n = 1; step();
    chk("R8", F_OE, 16'd3, 16'hFFFF);
    ras_n = 0; addr = 4'd0; exp_open++; step();
    chk("R8", F_KIND, 16'd5, 16'hFFFF);
    chk("R8", F_ACT, {12'b0, exp_cnt}, 16'hFFFF);
    chk("R8", F_OE, 16'd3, 16'hFFFF);
    chk("R8", F_DQ, 16'h125A, 16'hFFFF);
    exp_cnt = exp_cnt + 4'd1;
    idle_all();

    // R11: read then late write in the same cycle
    ras_n = 0; addr = 4'd4; exp_open++; step();
    addr = 4'd6; oe_n = 0; step();
    lcas_n = 0; ucas_n = 0; step();
    din = 16'h7777; we_n = 0; step();
    chk("R11", F_KIND, 16'd3, 16'hFFFF);
    idle_all();
    rd_cycle(4'd4, 4'd6, 2'b11, 16'h7777, "R11");

    // R9: sweep the counter through its top row and back to zero
    for (int i = 0; i < 14; i++) cbr("R9");
    own("R9", exp_cnt == 4'd0, exp_cnt, 0);
    cbr("R9");

    // R10: one pulse per row-strobe fall and every row opened within the window
    step();
    own("R10", n_open == exp_open, n_open, exp_open);
    for (int r = 0; r < 16; r++)
      own("R10", (cyc - last_open[r]) < RET_CYC, cyc - last_open[r], RET_CYC);

    summary();
    $finish;
  end
endmodule